// File: doc/BRIEF.md
# Input Change Interrupt Pulse Generator

This block watches a group of switch or sensor lines, such as joystick direction contacts or the photo sensors of a pointing device. It raises an active-low interrupt pulse each time any of those lines changes. A processor then reads the port only when something has actually moved, and never has to poll it. The live lines are first brought into the clock domain. A per-bit polarity mask is applied so that sensors behind an inverting buffer read the right way. The result is then compared with a held reference copy.

The reference copy trails the live value. It takes the new input value only after a programmable number of clock cycles without a further change. Until that happens the equality output stays low, and so the length of the pulse is set by that delay. If another change arrives during a pulse, the delay starts over, so a burst of activity gives one long pulse rather than several. If the lines go back to the held value before the delay ends, the pulse ends early. The held reference is also available as an output, so the rest of the system can read a settled, polarity-corrected view of the lines.

Top module: `chg_irq_gen`

## Requirements
- R1: While reset is high, and on the cycle after it, `match_o` and `irq_n_o` are both 1. The reference tracks the synchronized inputs during reset, so a reset held for at least three cycles over any stable input gives no pulse after release.
- R2: A change of one or more bits of `sense_in` drives `match_o` low on the third rising clock edge after the change: two synchronizer stages, then the output register.
- R3: When no further change follows, `match_o` stays low for exactly `DELAY` clock cycles and then returns to 1.
- R4: `settled_o` takes the new value on the edge `DELAY`+2 after the input change, one cycle before `match_o` returns high. `settled_o` never changes while `match_o` is high.
- R5: A further change that reaches the reference logic while the pulse is active restarts the delay. `match_o` stays low without a gap and returns high on the edge `DELAY`+3 after the latest change. `settled_o` skips the intermediate value.
- R6: If the inputs return to the value held in `settled_o` before the delay ends, `match_o` returns high on the third edge after the return, and `settled_o` does not change.
- R7: Applying an input value equal to the one already present gives no pulse, and `match_o` stays 1.
- R8: Bit i of `settled_o` equals bit i of `sense_in` inverted when bit i of `INV_MASK` is 1, and not inverted when it is 0.
- R9: `irq_n_o` is a separate register that carries the same value as `match_o` in every cycle: low during a pulse, high when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_in | input | WIDTH | Asynchronous switch or sensor lines |
| match_o | output | 1 | 1 when the reference equals the conditioned inputs |
| irq_n_o | output | 1 | Active-low interrupt pulse |
| settled_o | output | WIDTH | Held reference value, polarity corrected |

## Verification
A table of input values is applied in turn: a change of the lowest bit alone, a change of the highest bit alone, a change of every bit at once, a return to zero, and repeats of the current value. These show that any bit position, or any number of bits, gives the same pulse of exactly the delay length, and that an unchanged value gives none. A second change two cycles into a pulse tells a restarted delay apart from two separate pulses. A change followed by a return to the held value tells the early end of a pulse apart from a completed one. A reset taken over a non-zero input, with a mask that mixes inverted and plain bits, shows that no startup pulse fires and that each bit's polarity is handled on its own.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  // Smallest delay the timer supports: the restart cycle needs one count.
  localparam int MIN_DELAY = 2;

  // Bits needed to count from 0 up to d-1.
  function automatic int cnt_bits(input int d);
    return (d < 2) ? 1 : $clog2(d);
  endfunction
endpackage

// File: rtl/chg_sync.sv
// Applies per-bit polarity, then two synchronizer stages, plus one extra
// stage used to detect a fresh change on the synchronized value.
module chg_sync #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] INV_MASK = '0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic             chg
);
  logic [WIDTH-1:0] pol;
  logic [WIDTH-1:0] stg1;
  logic [WIDTH-1:0] stg2;
  logic [WIDTH-1:0] stg3;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pol
    if (INV_MASK[i]) begin : g_inv
      assign pol[i] = ~raw[i];
    end else begin : g_pass
      assign pol[i] = raw[i];
    end
  end

  // No reset: these flops keep sampling during reset so the reference
  // can start equal to the live inputs.
  always_ff @(posedge clk) begin
    stg1 <= pol;
    stg2 <= stg1;
    stg3 <= stg2;
  end

  assign cur = stg2;
  assign chg = |(stg2 ^ stg3);
endmodule

// File: rtl/chg_timer.sv
// Counts cycles of mismatch since the latest change and flags expiry.
module chg_timer
  import chg_irq_pkg::*;
#(
  parameter int DELAY = 4,
  localparam int CW   = cnt_bits(DELAY)
) (
  input  logic clk,
  input  logic rst,
  input  logic diff,
  input  logic chg,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = diff && !chg && (cnt == CW'(DELAY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!diff) begin
      cnt <= '0;
    end else if (chg) begin
      cnt <= CW'(1);
    end else if (expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/chg_ref.sv
// Holds the reference copy and registers the two outputs.
module chg_ref #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  input  logic             expire,
  output logic [WIDTH-1:0] ref_q,
  output logic             diff,
  output logic             match_q,
  output logic             irq_q
);
  assign diff = (cur != ref_q);

  always_ff @(posedge clk) begin
    if (rst || expire) begin
      ref_q <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b1;
      irq_q   <= 1'b1;
    end else begin
      match_q <= !diff;
      irq_q   <= !diff;
    end
  end
endmodule

// File: rtl/chg_irq_gen.sv
module chg_irq_gen
  import chg_irq_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter int               DELAY    = 4,
  parameter logic [WIDTH-1:0] INV_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sense_in,
  output logic             match_o,
  output logic             irq_n_o,
  output logic [WIDTH-1:0] settled_o
);
  localparam int DLY = (DELAY < MIN_DELAY) ? MIN_DELAY : DELAY;

  logic [WIDTH-1:0] cur;
  logic             chg;
  logic             diff;
  logic             expire;

  chg_sync #(.WIDTH(WIDTH), .INV_MASK(INV_MASK)) u_sync (
    .clk (clk),
    .raw (sense_in),
    .cur (cur),
    .chg (chg)
  );

  chg_timer #(.DELAY(DLY)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .diff   (diff),
    .chg    (chg),
    .expire (expire)
  );

  chg_ref #(.WIDTH(WIDTH)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .cur     (cur),
    .expire  (expire),
    .ref_q   (settled_o),
    .diff    (diff),
    .match_q (match_o),
    .irq_q   (irq_n_o)
  );
endmodule

// File: rtl/chg_irq_chk.sv
module chg_irq_chk #(
  parameter int WIDTH = 8,
  parameter int DELAY = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] sense_in,
  input logic             match_o,
  input logic             irq_n_o,
  input logic [WIDTH-1:0] settled_o
);
  logic [2:0]  since_rst;
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || match_o) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (match_o && irq_n_o));

  // R2
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(match_o) && since_rst == 3'd7) |-> ($past(sense_in, 3) != $past(sense_in, 4)));

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && settled_o != $past(settled_o)) |-> (32'(low_run) >= DELAY - 1));

  // R4
  settle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && settled_o != $past(settled_o)) |-> !match_o);

  // R9
  irq_same_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == match_o);
endmodule

bind chg_irq_gen chg_irq_chk #(.WIDTH(WIDTH), .DELAY(DELAY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sense_in  (sense_in),
  .match_o   (match_o),
  .irq_n_o   (irq_n_o),
  .settled_o (settled_o)
);

// File: tb/sim_chg_irq_gen.sv
module sim_chg_irq_gen;
  localparam int         W    = 8;
  localparam int         D    = 4;
  localparam logic [7:0] MASK = 8'hA5;
  localparam int         N    = 12;

  // {input value, expected low cycles (0 = no pulse)}
  localparam logic [15:0] TBL [0:5] = '{
    {8'h01, 8'(D)}, {8'h81, 8'(D)}, {8'h81, 8'h00},
    {8'h7E, 8'(D)}, {8'h7E, 8'h00}, {8'h00, 8'(D)}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sense_in = '0;
  logic         match_o;
  logic         irq_n_o;
  logic [W-1:0] settled_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic         cm [1:N];
  logic         ci [1:N];
  logic [W-1:0] cs [1:N];
  logic [W-1:0] held;

  always #10 clk = ~clk;

  chg_irq_gen #(.WIDTH(W), .DELAY(D), .INV_MASK(MASK)) u0 (
    .clk (clk), .rst (rst), .sense_in (sense_in),
    .match_o (match_o), .irq_n_o (irq_n_o), .settled_o (settled_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive v1, optionally v2 after 'gap' edges, record N edges.
  task automatic capture(input logic [W-1:0] v1, input int gap, input logic [W-1:0] v2);
    @(negedge clk) sense_in = v1;
    for (int k = 1; k <= N; k++) begin
      @(posedge clk); #1;
      cm[k] = match_o; ci[k] = irq_n_o; cs[k] = settled_o;
      if (k == gap) begin
        @(negedge clk) sense_in = v2;
      end
    end
  endtask

  // Expected low window k = lo..hi (lo > hi means no pulse).
  task automatic check_window(input int lo, input int hi, input string req);
    for (int k = 1; k <= N; k++) begin
      chk(cm[k] == ((k >= lo && k <= hi) ? 1'b0 : 1'b1), req, int'(cm[k]), k);
      chk(ci[k] == cm[k], "R9 irq_n_o tracks match_o", int'(ci[k]), int'(cm[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk(match_o == 1'b1 && irq_n_o == 1'b1, "R1 idle after reset", int'({match_o, irq_n_o}), 3);
    chk(settled_o == (8'h00 ^ MASK), "R8 settled after reset", int'(settled_o), int'(8'h00 ^ MASK));
    held = 8'h00;

    // Table walk: R2, R3, R4, R7, R8
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      int lw;
      v  = TBL[i][15:8];
      lw = int'(TBL[i][7:0]);
      capture(v, 0, v);
      if (lw == 0) begin
        check_window(1, 0, "R7 no pulse on repeat");
      end else begin
        check_window(3, lw + 2, "R2/R3 pulse window");
        chk(cs[D+1] == (held ^ MASK), "R4 settled old before load", int'(cs[D+1]), int'(held ^ MASK));
        chk(cs[D+2] == (v ^ MASK), "R4 settled new at load", int'(cs[D+2]), int'(v ^ MASK));
      end
      chk(cs[N] == (v ^ MASK), "R8 settled polarity", int'(cs[N]), int'(v ^ MASK));
      held = v;
    end

    // R5: second change two edges into the pulse stretches it
    capture(8'h10, 2, 8'h30);
    check_window(3, D + 4, "R5 restart stretch");
    chk(cs[D+3] == (held ^ MASK), "R5 settled held", int'(cs[D+3]), int'(held ^ MASK));
    chk(cs[D+4] == (8'h30 ^ MASK), "R5 settled latest", int'(cs[D+4]), int'(8'h30 ^ MASK));
    for (int k = 1; k <= N; k++)
      chk(cs[k] != (8'h10 ^ MASK), "R5 intermediate skipped", int'(cs[k]), int'(8'h30 ^ MASK));
    held = 8'h30;

    // R6: change then return to the held value
    capture(8'h22, 2, 8'h30);
    check_window(3, 4, "R6 early end on return");
    for (int k = 1; k <= N; k++)
      chk(cs[k] == (8'h30 ^ MASK), "R6 settled unchanged", int'(cs[k]), int'(8'h30 ^ MASK));

    // R1: reset over a non-zero input gives no startup pulse
    @(negedge clk) begin rst = 1'b1; sense_in = 8'h3C; end
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #1;
      chk(match_o == 1'b1 && irq_n_o == 1'b1, "R1 no startup pulse", int'({match_o, irq_n_o}), 3);
    end
    chk(settled_o == (8'h3C ^ MASK), "R8 settled after reset", int'(settled_o), int'(8'h3C ^ MASK));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule